// File: doc/BRIEF.md
# Dual-Carrier Data Signal Modulator

The block builds a modulated output from three signals. One modulation bit chooses between two carriers. When the bit is 1 the high carrier reaches the output, and when it is 0 the low carrier does. The modulation bit comes from a software bit or from one of the input lines. Each carrier comes from an input line chosen by a 4-bit code, and each can be inverted. Each carrier can also be told to delay a switch away from itself until its own falling edge. This keeps switching from cutting a carrier pulse short.

Software sets up the block through a small register write port with four 8-bit registers, and can read every register back. The control register carries the module enable, the pin output enable, the output polarity and the software modulation bit. It also holds a stored slew-rate bit and a read-only status bit that shows the final modulated value. The input bundle has sixteen lines. Carrier codes 1 to 8 map to lines 0 to 7, which carry the external carrier pins, a reference clock and the PWM channels.

Top module: `dual_carrier_mod`

## Requirements
- R1: After reset every register reads 0 and `mod_out` is 0.
- R2: A carrier select code of 0 gives constant 0, codes 1 to 8 give `sig_in[code-1]`, and codes 9 to 15 give constant 0.
- R3: Modulation source code 0 (source register bits 3:0) selects the software bit (control bit 0). Codes 1 to 15 select `sig_in[code-1]`.
- R4: With sync off, the output follows the high carrier while the modulation bit is 1 and the low carrier while it is 0. Both the carrier and the modulation bit are used in the same cycle.
- R5: A carrier polarity bit (bit 6 of its register) inverts that carrier before it is chosen.
- R6: The output polarity bit (control bit 4) inverts the chosen carrier. When the output enable (control bit 6) is 0, `mod_out` is held at 0.
- R7: When the module enable (control bit 7) is 0, both `mod_out` and the status bit are 0.
- R8: With low-carrier sync set (low register bit 5), a change from the low carrier to the high carrier waits for a cycle where the low carrier is 0 after being 1 in the previous cycle.
- R9: With high-carrier sync set (high register bit 5), a change from the high carrier to the low carrier waits for a falling edge of the high carrier, in the same way.
- R10: Control bit 3 is read-only. It returns the final output value before output-enable gating, as registered at the previous clock edge. Writes to this bit are ignored.
- R11: The register addresses are 0 for control, 1 for source, 2 for the high carrier and 3 for the low carrier. Unused bits read 0: control bits 2:1, source bits 6:4 and carrier bit 4. The stored-only bits read back as written: slew-rate (control bit 5), source disable (source bit 7) and carrier disable (bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register readback |
| sig_in | input | 16 | Carrier and modulation input lines |
| mod_out | output | 1 | Modulated output |

## Verification
A carrier switch and a falling edge on the outgoing carrier can fall in the same cycle. So can a register write that changes the modulation bit and a carrier edge. The directed sync cases hold the outgoing carrier high after the modulation bit flips and check that the output stays on it. In the cycle where that carrier falls, the incoming carrier is driven to the opposite level, so a switch that comes one cycle early or late shows at the pin. Random runs mix writes, line changes and readback, and judge every cycle against a bench model of the selection state.

// File: rtl/dual_carrier_mod.sv
module dual_carrier_mod #(
  parameter int NIN  = 16,
  parameter int NCAR = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [1:0]     rd_addr,
  output logic [7:0]     rd_data,
  input  logic [NIN-1:0] sig_in,
  output logic           mod_out
);
  localparam logic [7:0] CTRL_MASK = 8'hF1;
  localparam logic [7:0] SRC_MASK  = 8'h8F;
  localparam logic [7:0] CAR_MASK  = 8'hEF;

  logic [7:0] ctrl_q, src_q, carh_q, carl_q;
  logic cur_q, ch_q, cl_q, stat_q;
  logic en, oe, opol, sw, hsync, lsync;
  logic ch, cl, modb, sel, y, fall_h, fall_l;

  function automatic logic pick_car(input logic [3:0] c, input logic [NIN-1:0] s);
    int i;
    i = int'(c);
    if (i == 0 || i > NCAR || i > NIN) return 1'b0;
    return s[i-1];
  endfunction

  assign en    = ctrl_q[7];
  assign oe    = ctrl_q[6];
  assign opol  = ctrl_q[4];
  assign sw    = ctrl_q[0];
  assign hsync = carh_q[5];
  assign lsync = carl_q[5];

  assign ch = pick_car(carh_q[3:0], sig_in) ^ carh_q[6];
  assign cl = pick_car(carl_q[3:0], sig_in) ^ carl_q[6];

  always_comb begin
    int i;
    i = int'(src_q[3:0]);
    if (i == 0)        modb = sw;
    else if (i > NIN)  modb = 1'b0;
    else               modb = sig_in[i-1];
  end

  assign fall_h = ch_q & ~ch;
  assign fall_l = cl_q & ~cl;

  always_comb begin
    sel = cur_q;
    if (modb && !cur_q)      sel = !lsync || fall_l;
    else if (!modb && cur_q) sel = !(!hsync || fall_h);
  end

  assign y       = en & ((sel ? ch : cl) ^ opol);
  assign mod_out = oe & y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      carh_q <= '0;
      carl_q <= '0;
      cur_q  <= 1'b0;
      ch_q   <= 1'b0;
      cl_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: ctrl_q <= wr_data & CTRL_MASK;
          2'd1: src_q  <= wr_data & SRC_MASK;
          2'd2: carh_q <= wr_data & CAR_MASK;
          default: carl_q <= wr_data & CAR_MASK;
        endcase
      end
      cur_q  <= en ? sel : modb;
      ch_q   <= ch;
      cl_q   <= cl;
      stat_q <= y;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0: rd_data = ctrl_q | {4'b0, stat_q, 3'b0};
      2'd1: rd_data = src_q;
      2'd2: rd_data = carh_q;
      default: rd_data = carl_q;
    endcase
  end
endmodule

module dual_carrier_mod_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic oe,
  input logic opol,
  input logic hsync,
  input logic lsync,
  input logic cur_q,
  input logic ch,
  input logic cl,
  input logic ch_q,
  input logic cl_q,
  input logic stat_q,
  input logic mod_out
);
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mod_out); // R7
  AST_OE_GATES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !mod_out); // R6
  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    oe |=> stat_q == $past(mod_out)); // R10
  AST_LSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oe && lsync && !cur_q && !(cl_q && !cl)) |-> mod_out == (cl ^ opol)); // R8
  AST_HSYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oe && hsync && cur_q && !(ch_q && !ch)) |-> mod_out == (ch ^ opol)); // R9
endmodule

bind dual_carrier_mod dual_carrier_mod_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .oe(oe), .opol(opol),
  .hsync(hsync), .lsync(lsync), .cur_q(cur_q), .ch(ch), .cl(cl),
  .ch_q(ch_q), .cl_q(cl_q), .stat_q(stat_q), .mod_out(mod_out)
);

// File: tb/sim_dual_carrier_mod.sv
module sim_dual_carrier_mod;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] sig_in = '0;
  logic        mod_out;

  dual_carrier_mod u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sig_in(sig_in),
    .mod_out(mod_out));

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_ctrl = 0, m_src = 0, m_h = 0, m_l = 0;
  bit m_cur = 0, m_chq = 0, m_clq = 0, m_stat = 0;

  function automatic bit car(logic [7:0] r, logic [15:0] s);
    int c = int'(r[3:0]);
    bit v = (c >= 1 && c <= 8) ? s[c-1] : 1'b0;
    return v ^ r[6];
  endfunction

  function automatic bit modbit(logic [15:0] s);
    int c = int'(m_src[3:0]);
    return (c == 0) ? m_ctrl[0] : s[c-1];
  endfunction

  function automatic bit esel(logic [15:0] s);
    bit m = modbit(s);
    bit ch = car(m_h, s);
    bit cl = car(m_l, s);
    if (m && !m_cur) return !m_l[5] || (m_clq && !cl);
    if (!m && m_cur) return m_h[5] && !(m_chq && !ch);
    return m_cur;
  endfunction

  function automatic bit ey(logic [15:0] s);
    bit c = esel(s) ? car(m_h, s) : car(m_l, s);
    return m_ctrl[7] & (c ^ m_ctrl[4]);
  endfunction

  function automatic logic [7:0] rb(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl | {4'b0, m_stat, 3'b0};
      2'd1: return m_src;
      2'd2: return m_h;
      default: return m_l;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [15:0] s, bit we, logic [1:0] wa, logic [7:0] wd,
                      logic [1:0] ra, string tag, int lit);
    bit y, nsel;
    @(negedge clk);
    sig_in = s; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    #2;
    y = ey(s);
    check(tag, {7'b0, mod_out}, {7'b0, y & m_ctrl[6]});
    check(tag, rd_data, rb(ra));
    if (lit >= 0) check({tag, " literal"}, {7'b0, mod_out}, {7'b0, lit[0]});
    nsel = esel(s);
    @(posedge clk);
    #1;
    m_cur  = m_ctrl[7] ? nsel : modbit(s);
    m_chq  = car(m_h, s);
    m_clq  = car(m_l, s);
    m_stat = y;
    if (we) begin
      case (wa)
        2'd0: m_ctrl = wd & 8'hF1;
        2'd1: m_src  = wd & 8'h8F;
        2'd2: m_h    = wd & 8'hEF;
        default: m_l = wd & 8'hEF;
      endcase
    end
    wr_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, string tag);
    step(sig_in, 1'b1, a, d, 2'd0, tag, -1);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 4; a++) step(16'hFFFF, 0, 0, 0, 2'(a), "R1", 0);

    // R11 layout and unused bits
    wr(2'd1, 8'hFF, "R11");
    step(16'h0, 0, 0, 0, 2'd1, "R11", -1);
    check("R11 src readback", rd_data, 8'h8F);
    wr(2'd2, 8'hFF, "R11");
    step(16'h0, 0, 0, 0, 2'd2, "R11", -1);
    check("R11 car readback", rd_data, 8'hEF);
    wr(2'd0, 8'h2E, "R10");
    step(16'h0, 0, 0, 0, 2'd0, "R10", -1);
    check("R10 status not writable", rd_data, 8'h20);

    // R2 carrier codes on the low carrier
    wr(2'd1, 8'h00, "R3");
    wr(2'd2, 8'h00, "R2");
    wr(2'd0, 8'hC0, "R2");
    for (int c = 0; c < 16; c++) begin
      wr(2'd3, 8'(c), "R2");
      step(16'hFFFF, 0, 0, 0, 2'd3, "R2", (c >= 1 && c <= 8) ? 1 : 0);
    end
    for (int c = 1; c <= 8; c++) begin
      wr(2'd3, 8'(c), "R2");
      step(16'(1) << (c - 1), 0, 0, 0, 2'd3, "R2", 1);
      step(~(16'(1) << (c - 1)), 0, 0, 0, 2'd3, "R2", 0);
    end
    // R5 polarity
    wr(2'd3, 8'h41, "R5");
    step(16'h0000, 0, 0, 0, 2'd3, "R5", 1);
    step(16'h0001, 0, 0, 0, 2'd3, "R5", 0);

    // R3 source codes; high carrier forced 1, low carrier 0
    wr(2'd2, 8'h40, "R3");
    wr(2'd3, 8'h00, "R3");
    for (int k = 1; k < 16; k++) begin
      wr(2'd1, 8'(k), "R3");
      step(16'(1) << (k - 1), 0, 0, 0, 2'd1, "R3", 1);
      step(~(16'(1) << (k - 1)), 0, 0, 0, 2'd1, "R3", 0);
    end
    wr(2'd1, 8'h00, "R3");
    wr(2'd0, 8'hC1, "R4");
    step(16'h0, 0, 0, 0, 2'd0, "R4", 1);
    wr(2'd0, 8'hC0, "R4");
    step(16'h0, 0, 0, 0, 2'd0, "R4", 0);

    // R6 output polarity and pin enable, R10 status
    wr(2'd0, 8'hD0, "R6");
    step(16'h0, 0, 0, 0, 2'd0, "R6", 1);
    wr(2'd0, 8'h90, "R6");
    step(16'h0, 0, 0, 0, 2'd0, "R6", 0);
    step(16'h0, 0, 0, 0, 2'd0, "R10", 0);
    check("R10 status with pin off", rd_data & 8'h08, 8'h08);
    // R7 disabled
    wr(2'd0, 8'h51, "R7");
    step(16'hFFFF, 0, 0, 0, 2'd0, "R7", 0);
    step(16'hFFFF, 0, 0, 0, 2'd0, "R7", 0);
    check("R7 status", rd_data & 8'h08, 8'h00);

    // R8 low sync: low=line0, high=line1
    wr(2'd3, 8'h21, "R8");
    wr(2'd2, 8'h02, "R8");
    wr(2'd0, 8'hC0, "R8");
    step(16'h0001, 0, 0, 0, 2'd3, "R8", 1);
    step(16'h0001, 1, 2'd0, 8'hC1, 2'd3, "R8", 1);
    step(16'h0001, 0, 0, 0, 2'd3, "R8 hold", 1);
    step(16'h0001, 0, 0, 0, 2'd3, "R8 hold", 1);
    step(16'h0002, 0, 0, 0, 2'd3, "R8 switch", 1);
    step(16'h0000, 0, 0, 0, 2'd3, "R8 after", 0);

    // R9 high sync
    wr(2'd2, 8'h22, "R9");
    wr(2'd3, 8'h01, "R9");
    step(16'h0002, 0, 0, 0, 2'd2, "R9", 1);
    step(16'h0002, 1, 2'd0, 8'hC0, 2'd2, "R9", 1);
    step(16'h0002, 0, 0, 0, 2'd2, "R9 hold", 1);
    step(16'h0001, 0, 0, 0, 2'd2, "R9 switch", 1);
    step(16'h0000, 0, 0, 0, 2'd2, "R9 after", 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit we = ($urandom_range(0, 9) == 0);
      logic [1:0] wa = 2'($urandom_range(0, 3));
      logic [7:0] wd = 8'($urandom);
      if (wa == 2'd0 && $urandom_range(0, 3) != 0) wd[7:6] = 2'b11;
      if (wa == 2'd1) wd[3:0] = 4'($urandom_range(0, 3));
      step(16'($urandom), we, wa, wd, 2'($urandom_range(0, 3)), "R4 random", -1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule